// File: doc/BRIEF.md
# Graphics Plane Pixel Unpacker

This block sits in the pixel path of a graphics overlay plane, after the memory fetch and before blending. Each cycle it can take one fetched memory word together with the plane's control word and produce a single 32-bit pixel laid out as alpha, red, green and blue, one byte each. A five-bit code in the control word selects the stored layout: 16-bit, 24-bit or 32-bit, with or without alpha. Two further control bits change how the stored word is read. One reverses the byte order of the pixel's bytes. The other moves the alpha field from the top of the pixel to the bottom. Setting both bits on a 32-bit code gives the blue-first variants. A range bit chooses whether an 8-bit alpha is output on the full 0..255 scale or on a reduced 0..128 scale.

The stored pixel sits in the low bytes of the input word: two bytes for codes 0x00, 0x06 and 0x07, three bytes for codes 0x01 and 0x04, and four bytes for codes 0x02 and 0x05. Bytes above that are ignored. Colour channels narrower than eight bits are widened by repeating their top bits in the freed low bits.

Input and output are valid/ready streams with one register stage between them. An accepted input appears at the output on the next cycle. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, it holds its value, and a new input is refused. A code outside the supported set yields a zero pixel with the unsupported flag set.

Top module: `px_unpack`

## Requirements
- R1: During and straight after reset, out_valid is 0 and in_ready is 1.
- R2: An input taken with in_valid and in_ready high appears with out_valid high on the next cycle. Pixels leave in the order they were taken, and every accepted pixel leaves once. in_ready is high exactly when out_valid is 0 or out_ready is 1.
- R3: While out_valid is 1 and out_ready is 0, out_valid, out_pixel and out_bad_fmt keep their values on the next cycle.
- R4: Format codes 0x03 and 0x08 to 0x1F (control bits 4:0) give out_bad_fmt = 1 and out_pixel = 0. Supported codes give out_bad_fmt = 0.
- R5: Code 0x00 is 16-bit colour with red in bits 15:11, green in 10:5 and blue in 4:0. A 5-bit channel c expands to {c, c[4:2]}, a 6-bit channel to {c, c[5:4]}, and alpha is 0xFF.
- R6: Code 0x01 is 24-bit colour with red in 23:16, green in 15:8 and blue in 7:0. Code 0x02 is the same colour in the low 24 bits of a 32-bit word whose top byte is ignored. Both give alpha 0xFF.
- R7: Code 0x04 is 24-bit, with an 8-bit alpha in bits 23:16 and 16-bit colour laid out as in R5 in bits 15:0.
- R8: Code 0x05 is 32-bit, with alpha in bits 31:24 and red, green and blue below it as in R6.
- R9: Code 0x06 has alpha in bit 15, expanded to 0x00 or 0xFF, and 5-bit red, green and blue in 14:10, 9:5 and 4:0. Code 0x07 has four 4-bit fields, alpha, red, green and blue from the top down, and each nibble n expands to {n, n}.
- R10: When control bit 23 is set, the bytes of the stored pixel (its 2, 3 or 4 low bytes) are taken in reverse order before the layouts above are applied.
- R11: When control bit 6 is set, the alpha field (or, for code 0x02, the unused byte) sits at the bottom of the pixel and the colour fields sit above it. This is applied after any byte reversal. It has no effect on codes 0x00 and 0x01.
- R12: For codes 0x04 and 0x05, control bit 5 = 1 passes the 8-bit alpha unchanged, and control bit 5 = 0 outputs (a+1)>>1. For all other codes, control bit 5 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl | input | 32 | Plane control word: format code in bits 4:0, alpha range in bit 5, alpha position swap in bit 6, byte reversal in bit 23 |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take an input this cycle |
| in_word | input | 32 | Fetched memory word holding one pixel in its low bytes |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_pixel | output | 32 | Unpacked pixel: alpha 31:24, red 23:16, green 15:8, blue 7:0 |
| out_bad_fmt | output | 1 | The pixel was sent with an unsupported format code |

## Verification
The only state in the block is the output register and its valid bit. A fault there shows at the ports within one cycle of the handshake that should have changed it. A lost, repeated or reordered pixel shows up as a mismatch with the expected queue on the next output beat. A value that changes while the consumer stalls breaks the hold rule on the very next cycle. A fault in decoding is combinational, so it appears in the pixel taken one cycle after the input that triggers it. The bench varies the byte-reversal, alpha-position and range bits, both independently and together, across every code, so that a bit wired into the wrong layout changes some pixel.

// File: rtl/px_unpack_pkg.sv
package px_unpack_pkg;

  localparam int PX_LANE_W  = 8;
  localparam int PX_LANES   = 4;
  localparam int PX_WORD_W  = PX_LANE_W * PX_LANES;
  localparam int PX_CNT_W   = $clog2(PX_LANES + 1);
  localparam int PX_FMT_W   = 5;

  typedef enum logic [PX_FMT_W-1:0] {
    FMT_RGB565   = 5'h00,
    FMT_RGB888   = 5'h01,
    FMT_RGB888X  = 5'h02,
    FMT_A8RGB565 = 5'h04,
    FMT_ARGB8888 = 5'h05,
    FMT_ARGB1555 = 5'h06,
    FMT_ARGB4444 = 5'h07
  } px_fmt_e;

  typedef struct packed {
    logic [PX_LANE_W-1:0] a;
    logic [PX_LANE_W-1:0] r;
    logic [PX_LANE_W-1:0] g;
    logic [PX_LANE_W-1:0] b;
  } argb_t;

  // number of bytes the stored pixel occupies for a given code
  function automatic logic [PX_CNT_W-1:0] fmt_lanes(input logic [PX_FMT_W-1:0] f);
    case (f)
      FMT_RGB565, FMT_ARGB1555, FMT_ARGB4444: fmt_lanes = PX_CNT_W'(2);
      FMT_RGB888, FMT_A8RGB565:               fmt_lanes = PX_CNT_W'(3);
      default:                                fmt_lanes = PX_CNT_W'(4);
    endcase
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] c);
    widen5 = {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    widen6 = {c, c[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] c);
    widen4 = {c, c};
  endfunction

endpackage

// File: rtl/px_lane_order.sv
module px_lane_order #(
  parameter  int LANES  = 4,
  parameter  int LANE_W = 8,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int W      = LANES * LANE_W
) (
  input  logic [W-1:0]     word_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             swap_i,
  output logic [W-1:0]     word_o
);

  logic [LANES-1:0][LANE_W-1:0] lin;
  assign lin = word_i;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [LANE_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 0; k < LANES; k++) begin
        if (gi < int'(count_i)) begin
          if (swap_i ? (k == int'(count_i) - 1 - gi) : (k == gi)) begin
            pick = lin[k];
          end
        end
      end
    end
    assign word_o[gi*LANE_W +: LANE_W] = pick;
  end

endmodule

// File: rtl/px_field_unpack.sv
module px_field_unpack
  import px_unpack_pkg::*;
(
  input  logic [PX_WORD_W-1:0] word_i,
  input  logic [PX_FMT_W-1:0]  fmt_i,
  input  logic                 aswap_i,
  output argb_t                px_o,
  output logic                 alpha8_o,
  output logic                 supported_o
);

  logic [31:0] n32;
  logic [23:0] n24;
  logic [15:0] n16a1, n16a4;

  // alpha at the bottom: rotate it back to the top of the pixel
  assign n32   = aswap_i ? {word_i[7:0], word_i[31:8]}  : word_i;
  assign n24   = aswap_i ? {word_i[7:0], word_i[23:8]}  : word_i[23:0];
  assign n16a1 = aswap_i ? {word_i[0],   word_i[15:1]}  : word_i[15:0];
  assign n16a4 = aswap_i ? {word_i[3:0], word_i[15:4]}  : word_i[15:0];

  always_comb begin
    px_o        = '0;
    alpha8_o    = 1'b0;
    supported_o = 1'b1;
    case (fmt_i)
      FMT_RGB565: begin
        px_o.a = 8'hFF;
        px_o.r = widen5(word_i[15:11]);
        px_o.g = widen6(word_i[10:5]);
        px_o.b = widen5(word_i[4:0]);
      end
      FMT_RGB888: begin
        px_o = {8'hFF, word_i[23:0]};
      end
      FMT_RGB888X: begin
        px_o = {8'hFF, n32[23:0]};
      end
      FMT_A8RGB565: begin
        alpha8_o = 1'b1;
        px_o.a   = n24[23:16];
        px_o.r   = widen5(n24[15:11]);
        px_o.g   = widen6(n24[10:5]);
        px_o.b   = widen5(n24[4:0]);
      end
      FMT_ARGB8888: begin
        alpha8_o = 1'b1;
        px_o     = n32;
      end
      FMT_ARGB1555: begin
        px_o.a = {8{n16a1[15]}};
        px_o.r = widen5(n16a1[14:10]);
        px_o.g = widen5(n16a1[9:5]);
        px_o.b = widen5(n16a1[4:0]);
      end
      FMT_ARGB4444: begin
        px_o.a = widen4(n16a4[15:12]);
        px_o.r = widen4(n16a4[11:8]);
        px_o.g = widen4(n16a4[7:4]);
        px_o.b = widen4(n16a4[3:0]);
      end
      default: begin
        supported_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/px_alpha_range.sv
module px_alpha_range #(
  parameter int CH_W = 8
) (
  input  logic [CH_W-1:0] alpha_i,
  input  logic            reduce_i,
  output logic [CH_W-1:0] alpha_o
);

  logic [CH_W:0] sum;
  assign sum     = {1'b0, alpha_i} + (CH_W+1)'(1);
  assign alpha_o = reduce_i ? sum[CH_W:1] : alpha_i;

endmodule

// File: rtl/px_unpack.sv
module px_unpack
  import px_unpack_pkg::*;
#(
  parameter int CTRL_W         = 32,
  parameter int FMT_LSB        = 0,
  parameter int ALPHA_FULL_BIT = 5,
  parameter int ALPHA_SWAP_BIT = 6,
  parameter int BYTE_SWAP_BIT  = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CTRL_W-1:0]    ctrl,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PX_WORD_W-1:0] in_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PX_WORD_W-1:0] out_pixel,
  output logic                 out_bad_fmt
);

  localparam logic [CTRL_W-1:0] USED_MASK =
      (CTRL_W'((1 << PX_FMT_W) - 1) << FMT_LSB) |
      (CTRL_W'(1) << ALPHA_FULL_BIT) |
      (CTRL_W'(1) << ALPHA_SWAP_BIT) |
      (CTRL_W'(1) << BYTE_SWAP_BIT);

  logic [PX_FMT_W-1:0]  fmt;
  logic                 full_range, alpha_swap, byte_swap;
  logic [PX_CNT_W-1:0]  lanes;
  logic [PX_WORD_W-1:0] ordered;
  argb_t                raw_px;
  logic                 alpha8, supported;
  logic [PX_LANE_W-1:0] alpha_out;
  logic                 unused_ctrl;

  assign fmt         = ctrl[FMT_LSB +: PX_FMT_W];
  assign full_range  = ctrl[ALPHA_FULL_BIT];
  assign alpha_swap  = ctrl[ALPHA_SWAP_BIT];
  assign byte_swap   = ctrl[BYTE_SWAP_BIT];
  assign unused_ctrl = ^(ctrl & ~USED_MASK);
  assign lanes       = fmt_lanes(fmt);

  px_lane_order #(
    .LANES  (PX_LANES),
    .LANE_W (PX_LANE_W)
  ) u_order (
    .word_i  (in_word),
    .count_i (lanes),
    .swap_i  (byte_swap),
    .word_o  (ordered)
  );

  px_field_unpack u_fields (
    .word_i      (ordered),
    .fmt_i       (fmt),
    .aswap_i     (alpha_swap),
    .px_o        (raw_px),
    .alpha8_o    (alpha8),
    .supported_o (supported)
  );

  px_alpha_range #(
    .CH_W (PX_LANE_W)
  ) u_range (
    .alpha_i  (raw_px.a),
    .reduce_i (alpha8 && !full_range),
    .alpha_o  (alpha_out)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pixel   <= '0;
      out_bad_fmt <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pixel   <= {alpha_out, raw_px.r, raw_px.g, raw_px.b};
        out_bad_fmt <= !supported;
      end
    end
  end

endmodule

// File: rtl/px_unpack_checks.sv
module px_unpack_checks #(
  parameter int CTRL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_pixel,
  input logic              out_bad_fmt
);

  logic unused_ctrl_hi;
  assign unused_ctrl_hi = ^ctrl[CTRL_W-1:6];

  // R2: an accepted word is on the output the next cycle
  p_accept_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2: a full output register that is not drained blocks the input
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: stalled output holds
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_bad_fmt)));

  // R4: unsupported code gives a zero pixel
  p_bad_is_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad_fmt) |-> (out_pixel == 32'h0));

  // R6: padded 24-bit colour is opaque
  p_opaque_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ctrl[4:0] == 5'h02) |=> (out_pixel[31:24] == 8'hFF && !out_bad_fmt));

  // R12: reduced range never exceeds 128
  p_reduced_alpha_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ctrl[4:0] == 5'h05 && !ctrl[5]) |=> (out_pixel[31:24] <= 8'd128));

endmodule

bind px_unpack px_unpack_checks #(.CTRL_W(CTRL_W)) u_checks (.*);

// File: tb/tb_px_unpack.sv
`timescale 1ns/1ps
module tb_px_unpack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pixel;
  logic        out_bad_fmt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  px_unpack dut (
    .clk, .rst_n, .ctrl, .in_valid, .in_ready, .in_word,
    .out_valid, .out_ready, .out_pixel, .out_bad_fmt
  );

  localparam logic [31:0] B_FULL = 32'h20;
  localparam logic [31:0] B_ASW  = 32'h40;
  localparam logic [31:0] B_BSW  = 32'h0080_0000;

  function automatic int w5(int x); return x * 8 + x / 4; endfunction
  function automatic int w6(int x); return x * 4 + x / 16; endfunction
  function automatic int w4(int x); return x * 17; endfunction

  // behavioural reference: {bad, pixel}
  function automatic logic [32:0] ref_px(logic [31:0] c, logic [31:0] w);
    int f, nb, k, a, r, g, b;
    bit alpha8;
    logic [31:0] v;
    f = int'(c[4:0]);
    alpha8 = 0;
    if (f == 0 || f == 6 || f == 7) nb = 2;
    else if (f == 1 || f == 4) nb = 3;
    else nb = 4;
    v = '0;
    for (int i = 0; i < nb; i++) begin
      k = c[23] ? nb - 1 - i : i;
      v[8*i +: 8] = w[8*k +: 8];
    end
    case (f)
      0: begin a = 255; r = w5(int'(v[15:11])); g = w6(int'(v[10:5])); b = w5(int'(v[4:0])); end
      1: begin a = 255; r = int'(v[23:16]); g = int'(v[15:8]); b = int'(v[7:0]); end
      2: begin
        a = 255;
        if (c[6]) begin r = int'(v[31:24]); g = int'(v[23:16]); b = int'(v[15:8]); end
        else      begin r = int'(v[23:16]); g = int'(v[15:8]);  b = int'(v[7:0]);  end
      end
      4: begin
        logic [15:0] cl;
        alpha8 = 1;
        if (c[6]) begin a = int'(v[7:0]);   cl = v[23:8]; end
        else      begin a = int'(v[23:16]); cl = v[15:0]; end
        r = w5(int'(cl[15:11])); g = w6(int'(cl[10:5])); b = w5(int'(cl[4:0]));
      end
      5: begin
        alpha8 = 1;
        if (c[6]) begin a = int'(v[7:0]);   r = int'(v[31:24]); g = int'(v[23:16]); b = int'(v[15:8]); end
        else      begin a = int'(v[31:24]); r = int'(v[23:16]); g = int'(v[15:8]);  b = int'(v[7:0]);  end
      end
      6: begin
        logic [14:0] cl;
        if (c[6]) begin a = v[0] ? 255 : 0;  cl = v[15:1]; end
        else      begin a = v[15] ? 255 : 0; cl = v[14:0]; end
        r = w5(int'(cl[14:10])); g = w5(int'(cl[9:5])); b = w5(int'(cl[4:0]));
      end
      7: begin
        logic [11:0] cl;
        if (c[6]) begin a = w4(int'(v[3:0]));   cl = v[15:4]; end
        else      begin a = w4(int'(v[15:12])); cl = v[11:0]; end
        r = w4(int'(cl[11:8])); g = w4(int'(cl[7:4])); b = w4(int'(cl[3:0]));
      end
      default: return {1'b1, 32'h0};
    endcase
    if (alpha8 && !c[5]) a = (a + 1) / 2;
    return {1'b0, a[7:0], r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic string tag_of(logic [31:0] c);
    case (int'(c[4:0]))
      0: return "R5";
      1, 2: return "R6";
      4: return "R7";
      5: return "R8";
      6, 7: return "R9";
      default: return "R4";
    endcase
  endfunction

  // driver-side expectation handed to the monitor
  string       drv_tag;
  bit          drv_has_exp;
  logic [32:0] drv_exp;

  logic [32:0] exp_q[$];
  string       tag_q[$];
  bit          stall_prev = 0;
  logic [32:0] stall_val;
  bit          acc_prev = 0;

  task automatic check(input bit ok, input string tag, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        check(out_valid && {out_bad_fmt, out_pixel} == stall_val, "R3",
              {out_bad_fmt, out_pixel}, stall_val);
      if (acc_prev)
        check(out_valid, "R2", {32'h0, out_valid}, 33'h1);
      check(in_ready == (!out_valid || out_ready), "R2", {32'h0, in_ready},
            {32'h0, (!out_valid || out_ready)});
      stall_prev = out_valid && !out_ready;
      stall_val  = {out_bad_fmt, out_pixel};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", {out_bad_fmt, out_pixel}, 33'h0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_bad_fmt, out_pixel} == e, t, {out_bad_fmt, out_pixel}, e);
        end
      end
      acc_prev = in_valid && in_ready;
      if (in_valid && in_ready) begin
        exp_q.push_back(drv_has_exp ? drv_exp : ref_px(ctrl, in_word));
        tag_q.push_back(drv_tag);
      end
    end
  end

  bit rdy_rand = 0;
  always @(posedge clk) begin
    #1;
    out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
  end

  task automatic send(input logic [31:0] c, input logic [31:0] w, input string tag,
                      input bit has_exp, input logic [32:0] e);
    ctrl        = c;
    in_word     = w;
    drv_tag     = tag;
    drv_has_exp = has_exp;
    drv_exp     = e;
    in_valid    = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_exp(input logic [31:0] c, input logic [31:0] w, input logic [31:0] px, input string tag);
    send(c, w, tag, 1'b1, {1'b0, px});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check(!out_valid && in_ready, "R1", {31'h0, out_valid, in_ready}, 33'h1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", {31'h0, out_valid, in_ready}, 33'h1);
    @(posedge clk); #1;

    // R5: 16-bit colour widening
    send_exp(32'h00, 32'h0000_F800, 32'hFFFF_0000, "R5");
    send_exp(32'h00, 32'h0000_07E0, 32'hFF00_FF00, "R5");
    send_exp(32'h00, 32'hABCD_0010, 32'hFF00_0084, "R5");
    // R6: top byte ignored, opaque
    send_exp(32'h02, 32'h5A12_3456, 32'hFF12_3456, "R6");
    send_exp(32'h01, 32'hEE12_3456, 32'hFF12_3456, "R6");
    // R7: 8-bit alpha with 16-bit colour
    send_exp(32'h04 | B_FULL, 32'h00C0_F800, 32'hC0FF_0000, "R7");
    send_exp(32'h04, 32'h00C0_F800, 32'h60FF_0000, "R7");
    // R8 / R12: full and reduced alpha range
    send_exp(32'h05 | B_FULL, 32'hFF11_2233, 32'hFF11_2233, "R8");
    send_exp(32'h05, 32'hFF11_2233, 32'h8011_2233, "R12");
    send_exp(32'h05, 32'h0111_2233, 32'h0111_2233, "R12");
    send_exp(32'h05, 32'h0011_2233, 32'h0011_2233, "R12");
    // R9: 1-bit and 4-bit alpha
    send_exp(32'h06, 32'h0000_8000, 32'hFF00_0000, "R9");
    send_exp(32'h06, 32'h0000_7FFF, 32'h00FF_FFFF, "R9");
    send_exp(32'h07, 32'h0000_5A3C, 32'h55AA_33CC, "R9");
    // R12: range bit has no effect outside the 8-bit alpha codes
    send_exp(32'h06 | B_FULL, 32'h0000_8000, 32'hFF00_0000, "R12");
    send_exp(32'h07, 32'h0000_F000, 32'hFF00_0000, "R12");
    // R10: byte reversal
    send_exp(32'h02 | B_BSW, 32'h1122_3344, 32'hFF33_2211, "R10");
    send_exp(32'h00 | B_BSW, 32'h0000_00F8, 32'hFFFF_0000, "R10");
    send_exp(32'h01 | B_BSW, 32'h0033_2211, 32'hFF11_2233, "R10");
    // R11: alpha at the bottom, and the blue-first variants
    send_exp(32'h02 | B_BSW | B_ASW, 32'h0033_2211, 32'hFF11_2233, "R11");
    send_exp(32'h05 | B_BSW | B_ASW | B_FULL, 32'h8033_2211, 32'h8011_2233, "R11");
    send_exp(32'h07 | B_ASW, 32'h0000_A5C3, 32'h33AA_55CC, "R11");
    send_exp(32'h00 | B_ASW, 32'h0000_F800, 32'hFFFF_0000, "R11");
    // R4: unsupported codes
    send(32'h03, 32'h1234_5678, "R4", 1'b1, {1'b1, 32'h0});
    send(32'h08, 32'h1234_5678, "R4", 1'b1, {1'b1, 32'h0});
    send(32'h1F, 32'hFFFF_FFFF, "R4", 1'b1, {1'b1, 32'h0});

    // R2 / R3: random sweep under back-pressure
    rdy_rand = 1;
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [31:0] c;
      sel = int'($urandom % 10);
      c = (sel < 9) ? 32'(sel) : 32'h1F;
      if ($urandom % 2) c = c | B_FULL;
      if ($urandom % 2) c = c | B_ASW;
      if ($urandom % 2) c = c | B_BSW;
      send(c, $urandom, tag_of(c), 1'b0, 33'h0);
      if ($urandom % 3 == 0) begin
        @(posedge clk); #1;
      end
    end
    rdy_rand = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    // R2: every accepted pixel has left
    check(exp_q.size() == 0 && !out_valid, "R2", 33'(exp_q.size()), 33'h0);
    finish_run();
  end

endmodule